// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one channel of a memory-to-memory copy engine. Software builds a linked list of 64-byte descriptors in memory and pulses a start command. The channel then walks the list on its own. For each descriptor it reads the source bytes into a local buffer and writes them to the destination. When the descriptor asks for it, the channel also writes a completion word to a fixed completion address. It follows each descriptor's next pointer until that pointer is zero.

Software can add work to a list the channel has already finished, or is still walking, by pulsing append. If the channel is idle, it re-reads only the next-pointer field of the last descriptor it fetched. If it is busy, it notes the request and re-reads that field once the current chain runs out.

A reset pulse halts the channel. When the channel is busy, the halt waits until the descriptor in flight has finished.

All memory traffic goes through one request/acknowledge master port. The port carries an 8-byte-aligned beat address, a byte count for the beat, a write strobe and the data.

Top module: `dmac_channel`

## Requirements
- R1: After reset the channel is idle. Busy is 0, the low three status bits (transfer state) read 3, the error flag is 0, both counters are 0 and no memory request is raised.
- R2: A start pulse while idle latches the chain address. One cycle later busy is 1 and the transfer state reads 0. The first request is a read of the chain address. The descriptor is then read as 8 consecutive 8-byte beats: beat 0 holds control in bits 31:0 and length in bits 63:32, beat 1 the source, beat 2 the destination, beat 3 the next pointer, and beats 4 to 7 are reserved. A start also clears the error flag.
- R3: Control bit 0 is the skip flag. When it is set, the descriptor is dropped with no copy and no error, and the channel goes idle. When it is clear, any control bit other than bit 1 being set, or a length of 0 or above the maximum transfer size (64 bytes by default), sets the error flag. The channel then goes idle without copying.
- R4: A valid descriptor reads the length in bytes from the source in 8-byte beats, then writes those beats to the destination. The last beat carries only the remaining byte count, so destination bytes past the length are left untouched.
- R5: When the destination write finishes, status bits 63:6 take the descriptor address shifted right by 6. Only if control bit 1 is set is the completion word written to the completion address. That word is the new status value OR 1.
- R6: When a descriptor finishes with a nonzero next pointer and no halt pending, the channel fetches the descriptor at that pointer.
- R7: An append while idle reads only the next-pointer field, at the last descriptor address plus 24. If it reads a nonzero value, that descriptor is processed. If it reads zero, the channel goes idle with no error and no copy.
- R8: An append while busy is held pending. When a descriptor finishes with a zero next pointer, a pending append starts the next-pointer re-read of R7.
- R9: A reset while idle sets the transfer state to 3 in the next cycle. A reset while busy waits until the current descriptor, including its completion word, has finished. The channel then goes idle with transfer state 3, fetches no further descriptors and drops any pending append.
- R10: At each completed write phase, the byte counter adds the descriptor length and the copy counter adds 1.
- R11: A raised request keeps its address and direction unchanged until it is acknowledged.
- R12: Busy is high in every state except idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse: begin the chain at chain_addr |
| cmd_append | input | 1 | Append pulse: re-read the last next pointer |
| cmd_reset | input | 1 | Halt pulse, deferred while busy |
| chain_addr | input | 64 | Address of the first descriptor (64-byte aligned) |
| cmpl_addr | input | 64 | Address the completion word is written to |
| mem_req | output | 1 | Memory request raised |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 64 | Beat address |
| mem_size | output | 4 | Valid bytes in the beat (1 to 8) |
| mem_wdata | output | 64 | Write data, little-endian |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Channel not idle |
| status | output | 64 | Bits 63:6 completed descriptor address field, bits 2:0 transfer state |
| err | output | 1 | Sticky descriptor error, cleared by start |
| byte_count | output | 32 | Total bytes copied |
| copy_count | output | 32 | Total descriptors copied |

## Verification
The assertions assume that start is never pulsed while busy, that cmpl_addr holds still while a request is outstanding, and that the memory acknowledges only a raised request. The stimulus meets these assumptions: it pulses start only after busy has been seen low, it sets every address before a command, and its memory model answers each request exactly once, one cycle after it rises. Every descriptor and buffer address the stimulus uses is 8-byte aligned, and every descriptor is 64-byte aligned. The expected completion word can therefore be derived from the descriptor address alone.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ADDR_W      = 64;
    localparam int DATA_W      = 64;
    localparam int DESC_BEATS  = 8;
    localparam int NEXT_BEAT   = 3;
    localparam int FLAG_SKIP   = 0;
    localparam int FLAG_NOTIFY = 1;

    localparam logic [2:0] XS_ACTIVE = 3'd0;
    localparam logic [2:0] XS_HALTED = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_READ,
        ST_WRITE,
        ST_CMPL,
        ST_ANEXT
    } ch_state_e;

    typedef struct packed {
        logic [31:0]       ctrl;
        logic [31:0]       len;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] nxt;
    } desc_t;

    function automatic logic [31:0] beats_of(input logic [31:0] len);
        return (len + 32'd7) >> 3;
    endfunction

    function automatic logic [3:0] beat_bytes(input logic [31:0] len,
                                              input logic [31:0] beat);
        logic [31:0] rem;
        rem = len - (beat << 3);
        return (rem >= 32'd8) ? 4'd8 : rem[3:0];
    endfunction

endpackage

// File: rtl/dmac_desc_capture.sv
module dmac_desc_capture
    import dmac_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [BEAT_W-1:0] beat,
    input  logic [DATA_W-1:0] rdata,
    output desc_t             desc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else if (cap_en) begin
            case (int'(beat))
                0: begin
                    desc.ctrl <= rdata[31:0];
                    desc.len  <= rdata[63:32];
                end
                1:         desc.src <= rdata;
                2:         desc.dst <= rdata;
                NEXT_BEAT: desc.nxt <= rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmac_copybuf.sv
module dmac_copybuf
    import dmac_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/dmac_stats.sv
module dmac_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic [31:0]      len,
    output logic [CNT_W-1:0] bytes,
    output logic [CNT_W-1:0] copies
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes  <= '0;
            copies <= '0;
        end else if (bump) begin
            bytes  <= bytes + CNT_W'(len);
            copies <= copies + 1'b1;
        end
    end

    a_r10_copy_step: assert property (@(posedge clk) disable iff (rst)
        bump |=> copies == $past(copies) + 1'b1);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(bytes) && $stable(copies));

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int MAX_BEATS = 8,
    localparam int BEAT_W   = $clog2((MAX_BEATS > DESC_BEATS) ? MAX_BEATS : DESC_BEATS),
    localparam int MAX_BYTES = MAX_BEATS * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_append,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] chain_addr,
    input  logic [ADDR_W-1:0] cmpl_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  desc_t             desc,
    input  logic [DATA_W-1:0] buf_rdata,
    output ch_state_e         state,
    output logic [BEAT_W-1:0] beat,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cap_en,
    output logic              buf_wr,
    output logic              copy_done,
    output logic [63:0]       status,
    output logic              err
);

    logic [ADDR_W-1:0] cur_desc;
    logic [63:0]       cmpl_word;
    logic [2:0]        xfer_st;
    logic [57:0]       done_field;
    logic              app_pend, halt_pend;

    logic [31:0]       beat32, xfer_beats;
    logic [ADDR_W-1:0] beat_off;
    logic              last_desc_beat, last_xfer, flags_bad, len_bad;
    logic              desc_done, drop_idle;

    assign beat32     = {{(32-BEAT_W){1'b0}}, beat};
    assign beat_off   = {{(ADDR_W-BEAT_W-3){1'b0}}, beat, 3'b000};
    assign xfer_beats = beats_of(desc.len);

    always_comb begin
        last_desc_beat = (beat32 == DESC_BEATS - 1);
        last_xfer      = (beat32 == xfer_beats - 32'd1);
        flags_bad      = (desc.ctrl & ~(32'd1 << FLAG_NOTIFY)) != 32'd0;
        len_bad        = (desc.len == 32'd0) || (desc.len > MAX_BYTES);
        copy_done      = (state == ST_WRITE) && mem_ack && last_xfer;
        desc_done      = (copy_done && !desc.ctrl[FLAG_NOTIFY]) ||
                         ((state == ST_CMPL) && mem_ack);
        drop_idle      = ((state == ST_DESC) && mem_ack && last_desc_beat &&
                          (desc.ctrl[FLAG_SKIP] || flags_bad || len_bad)) ||
                         ((state == ST_ANEXT) && mem_ack && (mem_rdata == '0));
        cap_en         = (state == ST_DESC) && mem_ack;
        buf_wr         = (state == ST_READ) && mem_ack;
    end

    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_WRITE) || (state == ST_CMPL);
        mem_size  = 4'd8;
        mem_wdata = '0;
        mem_addr  = '0;
        case (state)
            ST_DESC:  mem_addr = cur_desc + beat_off;
            ST_READ: begin
                mem_addr = desc.src + beat_off;
                mem_size = beat_bytes(desc.len, beat32);
            end
            ST_WRITE: begin
                mem_addr  = desc.dst + beat_off;
                mem_size  = beat_bytes(desc.len, beat32);
                mem_wdata = buf_rdata;
            end
            ST_CMPL: begin
                mem_addr  = cmpl_addr;
                mem_wdata = cmpl_word;
            end
            ST_ANEXT: mem_addr = cur_desc + ADDR_W'(NEXT_BEAT * 8);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            beat       <= '0;
            cur_desc   <= '0;
            cmpl_word  <= '0;
            xfer_st    <= XS_HALTED;
            done_field <= '0;
            app_pend   <= 1'b0;
            halt_pend  <= 1'b0;
            err        <= 1'b0;
        end else begin
            if (state != ST_IDLE) begin
                if (cmd_append) app_pend  <= 1'b1;
                if (cmd_reset)  halt_pend <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    beat <= '0;
                    if (cmd_start) begin
                        xfer_st  <= XS_ACTIVE;
                        err      <= 1'b0;
                        cur_desc <= chain_addr;
                        state    <= ST_DESC;
                    end else if (cmd_append) begin
                        state <= ST_ANEXT;
                    end else if (cmd_reset) begin
                        xfer_st <= XS_HALTED;
                    end
                end
                ST_DESC: if (mem_ack) begin
                    if (!last_desc_beat) begin
                        beat <= beat + 1'b1;
                    end else begin
                        beat <= '0;
                        if (!desc.ctrl[FLAG_SKIP] && (flags_bad || len_bad))
                            err <= 1'b1;
                        state <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    if (last_xfer) begin
                        beat  <= '0;
                        state <= ST_WRITE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                ST_WRITE: if (mem_ack) begin
                    if (last_xfer) begin
                        beat       <= '0;
                        done_field <= cur_desc[63:6];
                        cmpl_word  <= {cur_desc[63:6], 3'b000, xfer_st} | 64'd1;
                        state      <= ST_CMPL;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                ST_ANEXT: if (mem_ack) begin
                    cur_desc <= mem_rdata;
                    beat     <= '0;
                    state    <= ST_DESC;
                end
                default: ;
            endcase
            if (desc_done) begin
                beat <= '0;
                if (halt_pend) begin
                    state     <= ST_IDLE;
                    xfer_st   <= XS_HALTED;
                    halt_pend <= 1'b0;
                    app_pend  <= 1'b0;
                end else if (desc.nxt != '0) begin
                    cur_desc <= desc.nxt;
                    state    <= ST_DESC;
                end else if (app_pend) begin
                    app_pend <= 1'b0;
                    state    <= ST_ANEXT;
                end else begin
                    state <= ST_IDLE;
                end
            end
            if (drop_idle) begin
                state     <= ST_IDLE;
                beat      <= '0;
                app_pend  <= 1'b0;
                halt_pend <= 1'b0;
                if (halt_pend) xfer_st <= XS_HALTED;
                if (state == ST_ANEXT) cur_desc <= cur_desc;
            end
        end
    end

    assign status = {done_field, 3'b000, xfer_st};

    a_r2_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !cmd_start);
    a_r2_start_clears_state: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cmd_start) |=> (status[2:0] == XS_ACTIVE) && mem_req && !err);
    a_r9_idle_halt: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cmd_start && !cmd_append && cmd_reset)
        |=> (status[2:0] == XS_HALTED) && !mem_req);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    a_r5_notify_only: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMPL) |-> desc.ctrl[FLAG_NOTIFY]);
    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && $past(state) != ST_WRITE) |-> $past(state) == ST_READ);
    a_r4_size_range: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_size != 4'd0) && (mem_size <= 4'd8));

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int MAX_BEATS = 8,
    parameter int CNT_W     = 32,
    localparam int BEAT_W   = $clog2((MAX_BEATS > DESC_BEATS) ? MAX_BEATS : DESC_BEATS),
    localparam int BUF_IW   = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_append,
    input  logic              cmd_reset,
    input  logic [63:0]       chain_addr,
    input  logic [63:0]       cmpl_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [3:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic [63:0]       status,
    output logic              err,
    output logic [CNT_W-1:0]  byte_count,
    output logic [CNT_W-1:0]  copy_count
);

    ch_state_e         state;
    logic [BEAT_W-1:0] beat;
    desc_t             desc;
    logic [DATA_W-1:0] buf_rdata;
    logic              cap_en, buf_wr, copy_done;

    dmac_seq #(.MAX_BEATS(MAX_BEATS)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_append(cmd_append), .cmd_reset(cmd_reset),
        .chain_addr(chain_addr), .cmpl_addr(cmpl_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .desc(desc), .buf_rdata(buf_rdata),
        .state(state), .beat(beat),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .cap_en(cap_en), .buf_wr(buf_wr), .copy_done(copy_done),
        .status(status), .err(err)
    );

    dmac_desc_capture #(.BEAT_W(BEAT_W)) u_desc (
        .clk(clk), .rst(rst), .cap_en(cap_en), .beat(beat),
        .rdata(mem_rdata), .desc(desc)
    );

    dmac_copybuf #(.DEPTH(MAX_BEATS)) u_buf (
        .clk(clk), .wr_en(buf_wr), .wr_idx(beat[BUF_IW-1:0]), .wr_data(mem_rdata),
        .rd_idx(beat[BUF_IW-1:0]), .rd_data(buf_rdata)
    );

    dmac_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .bump(copy_done), .len(desc.len),
        .bytes(byte_count), .copies(copy_count)
    );

    assign busy = (state != ST_IDLE);

    a_r12_busy_tracks_req: assert property (@(posedge clk) disable iff (rst)
        busy == mem_req);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !busy && !err && (status[2:0] == XS_HALTED) && (copy_count == '0));

endmodule

// File: tb/sim_dmac_channel.sv
`timescale 1ns/1ps
module sim_dmac_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0, cmd_append = 1'b0, cmd_reset = 1'b0;
    logic [63:0] chain_addr = '0, cmpl_addr = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_size;
    logic        busy, err;
    logic [63:0] status;
    logic [31:0] byte_count, copy_count;

    int checks = 0, fails = 0, r11_bad = 0;
    int exp_bytes = 0, exp_copies = 0;
    logic [63:0] mem [512];
    logic [63:0] lat_addr;
    logic        lat_we;

    always #10 clk = ~clk;

    dmac_channel u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_append(cmd_append),
        .cmd_reset(cmd_reset), .chain_addr(chain_addr), .cmpl_addr(cmpl_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .status(status), .err(err),
        .byte_count(byte_count), .copy_count(copy_count)
    );

    // memory model: answers each request one cycle after it is raised
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (mem_we)
                for (int b = 0; b < 8; b++)
                    if (b < int'(mem_size))
                        mem[mem_addr[11:3]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            mem_rdata <= mem[mem_addr[11:3]];
            mem_ack   <= 1'b1;
            lat_addr  <= mem_addr;
            lat_we    <= mem_we;
        end else begin
            if (mem_ack && (mem_addr !== lat_addr || mem_we !== lat_we)) r11_bad++;
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int s, input int w);
        return {32'(s * 977 + w), 32'(w * 131 + 7)} ^ 64'hC3C3_5A5A_0F0F_9696;
    endfunction

    function automatic logic [7:0] mbyte(input int a);
        return mem[(a >> 3) & 511][(a & 7) * 8 +: 8];
    endfunction

    task automatic put_desc(input int at, input logic [31:0] ctrl, input logic [31:0] len,
                            input logic [63:0] src, input logic [63:0] dst,
                            input logic [63:0] nxt);
        mem[(at >> 3) + 0] = {len, ctrl};
        mem[(at >> 3) + 1] = src;
        mem[(at >> 3) + 2] = dst;
        mem[(at >> 3) + 3] = nxt;
        for (int k = 4; k < 8; k++) mem[(at >> 3) + k] = '0;
    endtask

    task automatic fill(input int at, input int words, input int seed);
        for (int k = 0; k < words; k++) mem[(at >> 3) + k] = (seed < 0) ? 64'd0 : pat(seed, k);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cmd_start = 1'b1;
        if (which == 1) cmd_append = 1'b1;
        if (which == 2) cmd_reset = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_append = 1'b0; cmd_reset = 1'b0;
    endtask

    task automatic wait_idle;
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // {ctrl[7:0], len[7:0], expect_err, expect_copy}
    localparam logic [17:0] VEC [8] = '{
        {8'h02, 8'd16, 1'b0, 1'b1},
        {8'h00, 8'd13, 1'b0, 1'b1},
        {8'h02, 8'd64, 1'b0, 1'b1},
        {8'h00, 8'd1,  1'b0, 1'b1},
        {8'h02, 8'd65, 1'b1, 1'b0},
        {8'h04, 8'd16, 1'b1, 1'b0},
        {8'h00, 8'd0,  1'b1, 1'b0},
        {8'h03, 8'd16, 1'b0, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 512; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 state", status[2:0], 3);
        chk("R1 err", err, 0);
        chk("R1 bytes", byte_count, 0);
        chk("R1 copies", copy_count, 0);
        chk("R1 req", mem_req, 0);

        cmpl_addr = 64'h0C0;
        chain_addr = 64'h100;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ctrl, len;
            logic e_err, e_cp;
            {ctrl, len, e_err, e_cp} = VEC[i];
            put_desc(32'h100, 32'(ctrl), 32'(len), 64'h400, 64'h800, 64'h0);
            fill(32'h400, 9, i);
            fill(32'h800, 10, -1);
            mem[32'h0C0 >> 3] = '0;
            pulse(0);
            chk("R2 busy", busy, 1);
            chk("R12 busy", busy, 1);
            chk("R2 state", status[2:0], 0);
            chk("R2 first addr", mem_addr, 64'h100);
            wait_idle();
            if (e_cp) begin
                exp_bytes += int'(len);
                exp_copies++;
            end
            chk("R3 err", err, 64'(e_err));
            chk("R10 copies", copy_count, 64'(exp_copies));
            chk("R10 bytes", byte_count, 64'(exp_bytes));
            for (int k = 0; k < int'(len) + 8 && k < 80; k++)
                chk("R4 dst byte", mbyte(32'h800 + k),
                    (e_cp && k < int'(len)) ? mbyte(32'h400 + k) : 8'h00);
            chk("R5 cmpl word", mem[32'h0C0 >> 3],
                (e_cp && ctrl[1]) ? 64'h101 : 64'h0);
            if (e_cp) chk("R5 status field", status[63:6], 64'h4);
        end

        pulse(2);
        chk("R9 idle halt", status[2:0], 3);
        chk("R9 idle stays", busy, 0);

        // chain of two descriptors
        put_desc(32'h100, 0, 16, 64'h400, 64'h800, 64'h140);
        put_desc(32'h140, 0, 16, 64'h480, 64'h880, 64'h0);
        fill(32'h400, 2, 20); fill(32'h480, 2, 21);
        fill(32'h800, 2, -1); fill(32'h880, 2, -1);
        pulse(0);
        wait_idle();
        exp_copies += 2; exp_bytes += 32;
        chk("R6 copies", copy_count, 64'(exp_copies));
        chk("R6 first dst", mem[32'h808 >> 3], pat(20, 1));
        chk("R6 second dst", mem[32'h888 >> 3], pat(21, 1));

        // append while idle, nonzero next
        mem[(32'h140 >> 3) + 3] = 64'h180;
        put_desc(32'h180, 0, 8, 64'h500, 64'h900, 64'h0);
        fill(32'h500, 1, 22); fill(32'h900, 1, -1);
        pulse(1);
        chk("R7 append busy", busy, 1);
        chk("R7 next addr", mem_addr, 64'h158);
        wait_idle();
        exp_copies += 1; exp_bytes += 8;
        chk("R7 copies", copy_count, 64'(exp_copies));
        chk("R7 dst", mem[32'h900 >> 3], pat(22, 0));

        // append while idle, zero next
        pulse(1);
        wait_idle();
        chk("R7 zero copies", copy_count, 64'(exp_copies));
        chk("R7 zero err", err, 0);

        // append while busy
        put_desc(32'h100, 0, 64, 64'h400, 64'h800, 64'h0);
        put_desc(32'h140, 0, 16, 64'h480, 64'h880, 64'h0);
        fill(32'h400, 8, 23); fill(32'h480, 2, 24);
        fill(32'h800, 8, -1); fill(32'h880, 2, -1);
        pulse(0);
        repeat (24) @(negedge clk);
        chk("R8 still busy", busy, 1);
        mem[(32'h100 >> 3) + 3] = 64'h140;
        pulse(1);
        wait_idle();
        exp_copies += 2; exp_bytes += 80;
        chk("R8 copies", copy_count, 64'(exp_copies));
        chk("R8 appended dst", mem[32'h888 >> 3], pat(24, 1));

        // reset while busy
        put_desc(32'h100, 2, 64, 64'h400, 64'h800, 64'h140);
        fill(32'h880, 2, -1);
        mem[32'h0C0 >> 3] = '0;
        pulse(0);
        repeat (24) @(negedge clk);
        chk("R9 still busy", busy, 1);
        pulse(2);
        wait_idle();
        exp_copies += 1; exp_bytes += 64;
        chk("R9 copies", copy_count, 64'(exp_copies));
        chk("R9 state", status[2:0], 3);
        chk("R9 no next", mem[32'h880 >> 3], 64'h0);
        chk("R9 cmpl done", mem[32'h0C0 >> 3], 64'h101);

        chk("R11 req stable", 64'(r11_bad), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule